// File: doc/BRIEF.md
# Rotating Triple-Buffer Sample Streamer with SPI Read-Out

This block sits between a sample source that delivers one 32-bit word at a steady rate and an external SPI master that collects the data in bulk. Incoming words are grouped into batches of 250 words, which is 1000 bytes, so one batch fills the receiver's buffer exactly. Three batch stores take turns in three roles. One store is being filled, one holds a finished batch that waits for the master, and one is being read out. Capture therefore never pauses while a transfer runs.

The SPI side is a read-only slave in mode 0. The master lowers chip-select, runs 8000 clocks and raises chip-select again. The block passes the SPI clock and chip-select through two-flop synchronisers into its own clock domain, so the master must keep each SPI clock level for at least four system clocks. A ready output tells the host that a finished batch is waiting. If the master falls so far behind that no store is free when a batch completes, the newest batch is dropped and a sticky overflow flag is set. A read that is cut short still frees its store and is counted.

Top module: `tbuf_spi_streamer`

## Requirements
- R1: After reset, `batch_ready`, `overflow`, `spi_miso` and `short_reads` are all 0.
- R2: A batch is complete when its 250th accepted word arrives, and `batch_ready` rises one clock after that word is accepted. After 249 words it stays 0.
- R3: Words that arrive while a batch is being read out are stored without loss. They form the next batch in arrival order.
- R4: `batch_ready` is 1 exactly while at least one complete batch is held and not being read. It falls once the synchronised falling edge of `spi_cs_n` starts the read of the only waiting batch.
- R5: A read sends the oldest held batch as 8000 bits. The words go out in arrival order, each word from bit 31 down to bit 0, so the most significant byte goes first and each byte starts with its MSB. The first bit is on `spi_miso` no later than six system clocks after `spi_cs_n` falls. Each later bit appears after a falling edge of `spi_sck` and is sampled by the master on the rising edge (mode 0).
- R6: A batch that completes while two finished batches are held, with none released in that cycle, is discarded. Its store is refilled from the start, the held batches stay unchanged, and `overflow` is set.
- R7: `overflow` stays 1 until reset.
- R8: When `spi_cs_n` rises before 8000 falling edges of `spi_sck`, the batch being read is released, so it is not sent again, and `short_reads` increments by one. A complete read releases the batch and leaves the counter unchanged.
- R9: When a release happens in the same cycle as a batch completion while two batches are held, the freed store is used, the new batch is kept and `overflow` stays 0.
- R10: Lowering `spi_cs_n` while no batch is waiting sends all-zero bits, releases nothing and leaves `short_reads` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | Input word strobe, one word per cycle when high |
| smp_data | input | 32 | Input word |
| spi_sck | input | 1 | SPI clock from the master, idle low |
| spi_cs_n | input | 1 | SPI chip-select from the master, active low |
| spi_miso | output | 1 | Serial data to the master |
| batch_ready | output | 1 | A finished batch is waiting to be read |
| overflow | output | 1 | Sticky: a batch was discarded for lack of a free store |
| short_reads | output | 8 | Number of reads ended early |

## Verification
The case that matters is a read ending in the same cycle that the fill store takes its 250th word while two batches are held, so that a release and a completion meet. The bench starts a read of the oldest batch and fills the next store to 249 words. It then raises chip-select and presents the last word exactly two clocks later, which is the synchroniser delay, so both events land on one clock edge. The result is judged at the ports. `overflow` must stay 0, `short_reads` must step by one, and the next reads must return the two batches that remain, oldest first.

// File: rtl/tbuf_spi_streamer.sv
module tbuf_spi_streamer #(
  parameter int SAMPLE_W  = 32,
  parameter int BATCH_LEN = 250,
  parameter int CNT_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  output logic                spi_miso,
  output logic                batch_ready,
  output logic                overflow,
  output logic [CNT_W-1:0]    short_reads
);
  localparam int NBUF  = 3;
  localparam int DEPTH = NBUF * BATCH_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = $clog2(BATCH_LEN);
  localparam int BITS  = BATCH_LEN * SAMPLE_W;
  localparam int BW    = $clog2(BITS + 1);
  localparam int SW    = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] mem [DEPTH];

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    wb, rb, occ;
  logic [IW-1:0] fcnt;
  logic          draining;
  logic [BW-1:0] bcnt;

  function automatic logic [1:0] nxt(input logic [1:0] x);
    return (x == 2'd2) ? 2'd0 : x + 2'd1;
  endfunction

  wire sck_fall  = sck_q[2] & ~sck_q[1];
  wire cs_begin  = cs_q[2] & ~cs_q[1];
  wire cs_end    = ~cs_q[2] & cs_q[1];
  wire waiting   = occ != {1'b0, draining};
  wire start     = cs_begin & waiting;
  wire rel       = cs_end & draining;
  wire fill_done = smp_valid && (fcnt == IW'(BATCH_LEN - 1));
  wire accept    = fill_done && !(occ == 2'd2 && !rel);

  assign batch_ready = waiting;

  logic [BW-1:0]       rd_pos, rd_sel;
  logic [AW-1:0]       rd_addr, wr_addr;
  logic [SAMPLE_W-1:0] rd_word;
  logic                rd_ok;

  assign rd_pos  = start ? '0 : bcnt + 1'b1;
  assign rd_ok   = rd_pos < BW'(BITS);
  assign rd_sel  = BW'(SAMPLE_W - 1) - (rd_pos % BW'(SAMPLE_W));
  assign rd_addr = AW'(rb) * AW'(BATCH_LEN) + (rd_ok ? AW'(rd_pos / BW'(SAMPLE_W)) : '0);
  assign rd_word = mem[rd_addr];
  assign wr_addr = AW'(wb) * AW'(BATCH_LEN) + AW'(fcnt);

  always_ff @(posedge clk)
    if (smp_valid) mem[wr_addr] <= smp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 3'b000;
      cs_q        <= 3'b111;
      wb          <= 2'd0;
      rb          <= 2'd0;
      occ         <= 2'd0;
      fcnt        <= '0;
      draining    <= 1'b0;
      bcnt        <= '0;
      spi_miso    <= 1'b0;
      overflow    <= 1'b0;
      short_reads <= '0;
    end else begin
      sck_q <= {sck_q[1:0], spi_sck};
      cs_q  <= {cs_q[1:0], spi_cs_n};

      if (smp_valid) fcnt <= fill_done ? '0 : fcnt + 1'b1;
      if (accept) wb <= nxt(wb);
      if (fill_done && !accept) overflow <= 1'b1;
      occ <= occ + 2'(accept) - 2'(rel);

      if (rel) begin
        rb       <= nxt(rb);
        draining <= 1'b0;
        if (bcnt != BW'(BITS)) short_reads <= short_reads + 1'b1;
      end else if (start) begin
        draining <= 1'b1;
      end

      if (start)
        bcnt <= '0;
      else if (draining && sck_fall && bcnt != BW'(BITS))
        bcnt <= bcnt + 1'b1;

      if (start || (draining && sck_fall && !cs_end))
        spi_miso <= rd_ok & rd_word[SW'(rd_sel)];
      else if (cs_end || !draining)
        spi_miso <= 1'b0;
    end
  end
endmodule

module tbuf_spi_streamer_chk #(
  parameter int BW    = 14,
  parameter int BITS  = 8000,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             batch_ready,
  input logic             overflow,
  input logic [CNT_W-1:0] short_reads,
  input logic [1:0]       occ,
  input logic [1:0]       wb,
  input logic [1:0]       rb,
  input logic             draining,
  input logic [BW-1:0]    bcnt
);
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r8_count_only_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !draining |=> $stable(short_reads));
  a_r3_fill_apart_from_held: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != 2'd0) |-> (wb != rb));
  a_r6_overflow_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(occ) == 2'd2));
  a_r4_ready_needs_batch: assert property (@(posedge clk) disable iff (!rst_n)
    batch_ready |-> (occ != 2'd0));
  a_r5_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(BITS));
endmodule

bind tbuf_spi_streamer tbuf_spi_streamer_chk #(.BW(BW), .BITS(BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .batch_ready(batch_ready), .overflow(overflow),
  .short_reads(short_reads), .occ(occ), .wb(wb), .rb(rb),
  .draining(draining), .bcnt(bcnt));

// File: tb/test_tbuf_spi_streamer.sv
module test_tbuf_spi_streamer;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic [31:0] smp_data = '0;
  logic spi_sck = 0, spi_cs_n = 1;
  logic spi_miso, batch_ready, overflow;
  logic [7:0] short_reads;

  int checks = 0, errors = 0, k = 0;
  logic [31:0] rx [250];

  localparam logic [31:0] TBL [8] = '{32'hA5C3_0F01, 32'h5A3C_F0E2, 32'h1234_5678, 32'hFEDC_BA98,
                                      32'h8000_0001, 32'h0F0F_F0F0, 32'h7E81_C33C, 32'h0000_FFFF};

  tbuf_spi_streamer i_tbuf_spi_streamer (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] smp(input int n);
    return TBL[n % 8] ^ (32'(n) << 12);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1; smp_data = smp(k); cyc(1);
      smp_valid = 0; k++;
      if (gap > 1) cyc(gap - 1);
    end
  endtask

  task automatic xfer(input int nbits);
    spi_cs_n = 0; cyc(6);
    for (int b = 0; b < nbits; b++) begin
      spi_sck = 1;
      rx[b / 32] = {rx[b / 32][30:0], spi_miso};
      cyc(4);
      spi_sck = 0; cyc(4);
    end
  endtask

  task automatic end_cs;
    spi_cs_n = 1; cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    chk("R1 batch_ready", batch_ready, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 miso", spi_miso, 0);
    chk("R1 short_reads", short_reads, 0);

    push(249, 1);
    chk("R2 not ready after 249", batch_ready, 0);
    push(1, 1);
    chk("R2 ready after 250th", batch_ready, 1);

    fork
      begin
        xfer(8000);
      end
      begin
        cyc(6);
        chk("R4 ready drops at read start", batch_ready, 0);
      end
      push(250, 250);
    join
    end_cs;
    for (int w = 0; w < 250; w++)
      chk($sformatf("R5 word %0d order", w), rx[w], smp(w));
    chk("R8 full read not counted", short_reads, 0);
    chk("R3 batch filled during read", batch_ready, 1);

    push(250, 2);
    xfer(32);
    chk("R3 first word of batch 1", rx[0], smp(250));
    chk("R4 ready held with second batch", batch_ready, 1);
    push(249, 2);
    spi_cs_n = 1; cyc(2);
    smp_valid = 1; smp_data = smp(k); cyc(1); smp_valid = 0; k++;
    cyc(4);
    chk("R9 no overflow on same-cycle release", overflow, 0);
    chk("R8 short read counted", short_reads, 1);
    chk("R9 ready", batch_ready, 1);

    push(250, 2);
    chk("R6 overflow set", overflow, 1);
    xfer(32); end_cs;
    chk("R6 oldest batch kept", rx[0], smp(500));
    push(250, 2);
    chk("R7 overflow sticky", overflow, 1);
    xfer(32); end_cs;
    chk("R9 batch from same-cycle completion", rx[0], smp(750));
    xfer(40); end_cs;
    chk("R6 discarded batch skipped", rx[0], smp(1250));
    chk("R8 short count", short_reads, 4);
    chk("R4 no batch left", batch_ready, 0);

    xfer(32);
    chk("R10 zeros when idle", rx[0], 0);
    end_cs;
    chk("R10 no count when idle", short_reads, 4);
    chk("R10 miso low", spi_miso, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule